// File: doc/BRIEF.md
# Boot Image Selector with Fallback Watchdog

This block chooses which of two configuration images a device runs and keeps watch over the chosen one. Out of power-on reset it always runs the factory image, located at address zero. It then reads three words from a parameter memory: an enable flag for the application image, that image's start address and a watchdog timeout. When the flag is set, it asks the configuration engine to load the application image and, once the load succeeds, starts a down-counting watchdog.

A failed load, an expired watchdog or an external request sends the device back to the factory image. A software write can start a load of the application image at any time. Every reload records its cause in a one-hot register. A small word-addressed register bank, with registered read data, exposes the mode, the watchdog controls, the application address and the cause. The configuration engine sits outside the block, behind a level request with acknowledge and error pulses.

Top module: `boot_image_selector`

## Requirements
- R1: After power-on reset the mode is factory (`app_mode`=0, offset 0 reads 0) and the cause register reads 0. The block reads parameter words in order on `pm_addr`: 0 (enable flag in bit 0), 1 (application address), 2 (watchdog timeout). It holds `pm_req` high until each `pm_ack`, which carries `pm_rdata`.
- R2: If the fetched flag bit 0 is 1, the block raises `cfg_req` with `cfg_addr` equal to the fetched address. After `cfg_ack` the mode becomes application (`app_mode`=1). If the flag is 0, no request is made and the mode stays factory.
- R3: `reg_rdata` returns, one clock edge later, the word at the `reg_addr` presented at that edge. The offsets are: 0 mode (0 factory, 1 application), 2 watchdog timeout, 3 watchdog enable (bit 0), 4 application address, 6 cause. Every other offset reads 0.
- R4: Writes with `reg_we` update offsets 2, 3 and 4, truncated to their widths. Writes to offsets 0 and 6 have no effect.
- R5: In application mode with the watchdog enabled, the counter is loaded with the timeout T when the load is acknowledged. It decrements once per clock. `cfg_req` rises with `cfg_addr`=0 exactly T+1 clock edges after the loading edge, and the cause becomes 0x1.
- R6: While offset 3 bit 0 is 0 the watchdog holds its count and never forces a reload. Setting the bit again resumes the count.
- R7: Writing a value with bit 0 set to offset 7 reloads the counter with T. The fallback then comes T+1 edges after that write edge.
- R8: A `cfg_err` pulse during any load switches `cfg_addr` to 0 at the next edge, with `cfg_req` still high. It sets the cause to 0x2, and the next `cfg_ack` leaves the block in factory mode.
- R9: Writing a value with bit 0 set to offset 8 while idle starts a load from the offset-4 address and sets the cause to 0x4. The following `cfg_ack` selects application mode.
- R10: An `ext_reconfig` pulse while idle starts a factory load and sets the cause to 0x8. In the same cycle it wins over watchdog expiry and over the software trigger, and watchdog expiry wins over the software trigger.
- R11: Reload requests (external, watchdog, software) that arrive during a fetch or a load in progress are ignored. The cause and the load target do not change.
- R12: The cause register holds its value across idle time, register writes and later successful loads until a new cause occurs. Only power-on reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| pm_req | output | 1 | Parameter-memory read request |
| pm_addr | output | 2 | Parameter word index |
| pm_rdata | input | DATA_W | Parameter word, valid with pm_ack |
| pm_ack | input | 1 | Parameter read done |
| cfg_req | output | 1 | Load request to the configuration engine |
| cfg_addr | output | ADDR_W | Image start address for the load |
| cfg_ack | input | 1 | Load completed |
| cfg_err | input | 1 | Load failed |
| ext_reconfig | input | 1 | External reload request (factory image) |
| reg_addr | input | 4 | Register word offset |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| app_mode | output | 1 | 1 while the application image runs |

## Verification
A wrong watchdog count shows as a load request that comes one or more edges early or late relative to the arming or kick edge. The bench therefore checks `cfg_req` at every edge of the window, not only at its end. A wrong load target shows on `cfg_addr` at the first edge after an error or trigger. A wrong cause or mode becomes visible two edges later through a register read. A stale or lost value in the register bank shows on the next read of that offset in the random read/write phase.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;
   typedef enum logic [1:0] {
      ST_FETCH = 2'd0,
      ST_LOAD  = 2'd1,
      ST_RUN   = 2'd2
   } boot_state_e;

   localparam int CAUSE_W    = 4;
   localparam int CAUSE_WDOG = 0;
   localparam int CAUSE_CERR = 1;
   localparam int CAUSE_SOFT = 2;
   localparam int CAUSE_EXT  = 3;

   localparam int REG_AW = 4;
   localparam logic [REG_AW-1:0] OFS_MODE  = 4'd0;
   localparam logic [REG_AW-1:0] OFS_TMO   = 4'd2;
   localparam logic [REG_AW-1:0] OFS_WDEN  = 4'd3;
   localparam logic [REG_AW-1:0] OFS_ADDR  = 4'd4;
   localparam logic [REG_AW-1:0] OFS_CAUSE = 4'd6;
   localparam logic [REG_AW-1:0] OFS_KICK  = 4'd7;
   localparam logic [REG_AW-1:0] OFS_TRIG  = 4'd8;

   localparam int PM_WORDS = 3;
   localparam logic [1:0] PM_LAST = 2'd2;
endpackage

// File: rtl/boot_sel_wdog.sv
module boot_sel_wdog #(
   parameter int CNT_W = 29
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             run,
   output logic             expire
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (run && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expire = run && !load && (cnt_q == '0);
endmodule

// File: rtl/boot_sel_regs.sv
module boot_sel_regs
   import boot_sel_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int WDOG_W = 29,
   parameter int DATA_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [REG_AW-1:0]  reg_addr,
   input  logic               reg_we,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [PM_WORDS-1:0] fetch_ld,
   input  logic [DATA_W-1:0]  fetch_data,
   input  logic               app_mode,
   input  logic [CAUSE_W-1:0] cause,
   output logic [ADDR_W-1:0]  app_addr,
   output logic [WDOG_W-1:0]  wd_tmo,
   output logic               wd_en,
   output logic               kick,
   output logic               sw_trig
);
   logic [ADDR_W-1:0] addr_q;
   logic [WDOG_W-1:0] tmo_q;
   logic              en_q;
   logic [DATA_W-1:0] rd_next;
   logic [DATA_W-1:0] rd_q;

   wire wr_hit_tmo  = reg_we && (reg_addr == OFS_TMO);
   wire wr_hit_en   = reg_we && (reg_addr == OFS_WDEN);
   wire wr_hit_addr = reg_we && (reg_addr == OFS_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         tmo_q  <= '0;
         en_q   <= 1'b0;
      end else begin
         if (fetch_ld[0])      en_q <= fetch_data[0];
         else if (wr_hit_en)   en_q <= reg_wdata[0];
         if (fetch_ld[1])      addr_q <= fetch_data[ADDR_W-1:0];
         else if (wr_hit_addr) addr_q <= reg_wdata[ADDR_W-1:0];
         if (fetch_ld[2])      tmo_q <= fetch_data[WDOG_W-1:0];
         else if (wr_hit_tmo)  tmo_q <= reg_wdata[WDOG_W-1:0];
      end
   end

   always_comb begin
      case (reg_addr)
         OFS_MODE:  rd_next = DATA_W'(app_mode);
         OFS_TMO:   rd_next = DATA_W'(tmo_q);
         OFS_WDEN:  rd_next = DATA_W'(en_q);
         OFS_ADDR:  rd_next = DATA_W'(addr_q);
         OFS_CAUSE: rd_next = DATA_W'(cause);
         default:   rd_next = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else        rd_q <= rd_next;
   end

   assign reg_rdata = rd_q;
   assign app_addr  = addr_q;
   assign wd_tmo    = tmo_q;
   assign wd_en     = en_q;
   assign kick      = reg_we && (reg_addr == OFS_KICK) && reg_wdata[0];
   assign sw_trig   = reg_we && (reg_addr == OFS_TRIG) && reg_wdata[0];
endmodule

// File: rtl/boot_sel_ctrl.sv
module boot_sel_ctrl
   import boot_sel_pkg::*;
#(
   parameter int ADDR_W = 24
) (
   input  logic                clk,
   input  logic                rst_n,
   output logic                pm_req,
   output logic [1:0]          pm_addr,
   input  logic                pm_ack,
   input  logic                pm_bit0,
   output logic [PM_WORDS-1:0] fetch_ld,
   output logic                cfg_req,
   output logic [ADDR_W-1:0]   cfg_addr,
   input  logic                cfg_ack,
   input  logic                cfg_err,
   input  logic [ADDR_W-1:0]   app_addr,
   input  logic                ext_req,
   input  logic                sw_trig,
   input  logic                wd_expire,
   output logic                app_mode,
   output logic                in_run,
   output logic                arm,
   output logic [CAUSE_W-1:0]  cause
);
   boot_state_e        state_q;
   logic [1:0]         idx_q;
   logic               flag_q;
   logic               tgt_app_q;
   logic               mode_q;
   logic [CAUSE_W-1:0] cause_q;

   function automatic logic [CAUSE_W-1:0] cause_bit(input int b);
      return CAUSE_W'(1) << b;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_FETCH;
         idx_q     <= '0;
         flag_q    <= 1'b0;
         tgt_app_q <= 1'b0;
         mode_q    <= 1'b0;
         cause_q   <= '0;
      end else begin
         case (state_q)
            ST_FETCH: if (pm_ack) begin
               if (idx_q == 2'd0) flag_q <= pm_bit0;
               if (idx_q == PM_LAST) begin
                  tgt_app_q <= flag_q;
                  state_q   <= flag_q ? ST_LOAD : ST_RUN;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            ST_LOAD: if (cfg_ack) begin
               mode_q  <= tgt_app_q;
               state_q <= ST_RUN;
            end else if (cfg_err) begin
               cause_q   <= cause_bit(CAUSE_CERR);
               tgt_app_q <= 1'b0;
            end
            ST_RUN: if (ext_req) begin
               cause_q   <= cause_bit(CAUSE_EXT);
               tgt_app_q <= 1'b0;
               state_q   <= ST_LOAD;
            end else if (wd_expire) begin
               cause_q   <= cause_bit(CAUSE_WDOG);
               tgt_app_q <= 1'b0;
               state_q   <= ST_LOAD;
            end else if (sw_trig) begin
               cause_q   <= cause_bit(CAUSE_SOFT);
               tgt_app_q <= 1'b1;
               state_q   <= ST_LOAD;
            end
            default: state_q <= ST_FETCH;
         endcase
      end
   end

   assign pm_req   = (state_q == ST_FETCH);
   assign pm_addr  = idx_q;
   assign fetch_ld = (pm_req && pm_ack) ? (PM_WORDS'(1) << idx_q) : '0;
   assign cfg_req  = (state_q == ST_LOAD);
   assign cfg_addr = tgt_app_q ? app_addr : '0;
   assign arm      = cfg_req && cfg_ack && tgt_app_q;
   assign in_run   = (state_q == ST_RUN) && mode_q;
   assign app_mode = mode_q;
   assign cause    = cause_q;
endmodule

// File: rtl/boot_image_selector.sv
module boot_image_selector
   import boot_sel_pkg::*;
#(
   parameter int ADDR_W = 24,
   parameter int WDOG_W = 29,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              pm_req,
   output logic [1:0]        pm_addr,
   input  logic [DATA_W-1:0] pm_rdata,
   input  logic              pm_ack,
   output logic              cfg_req,
   output logic [ADDR_W-1:0] cfg_addr,
   input  logic              cfg_ack,
   input  logic              cfg_err,
   input  logic              ext_reconfig,
   input  logic [3:0]        reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              app_mode
);
   generate
      if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr_w
         $error("boot_image_selector: ADDR_W must lie in 1..DATA_W");
      end
      if (WDOG_W < 1 || WDOG_W > DATA_W) begin : g_bad_wdog_w
         $error("boot_image_selector: WDOG_W must lie in 1..DATA_W");
      end
      if (DATA_W < CAUSE_W) begin : g_bad_data_w
         $error("boot_image_selector: DATA_W too narrow for the cause field");
      end
   endgenerate

   logic [PM_WORDS-1:0] fetch_ld_w;
   logic [ADDR_W-1:0]   app_addr_w;
   logic [WDOG_W-1:0]   wd_tmo_w;
   logic                wd_en_w;
   logic                kick_w;
   logic                sw_trig_w;
   logic                in_run_w;
   logic                arm_w;
   logic                wd_expire_w;
   logic [CAUSE_W-1:0]  cause_w;

   boot_sel_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .pm_req    (pm_req),
      .pm_addr   (pm_addr),
      .pm_ack    (pm_ack),
      .pm_bit0   (pm_rdata[0]),
      .fetch_ld  (fetch_ld_w),
      .cfg_req   (cfg_req),
      .cfg_addr  (cfg_addr),
      .cfg_ack   (cfg_ack),
      .cfg_err   (cfg_err),
      .app_addr  (app_addr_w),
      .ext_req   (ext_reconfig),
      .sw_trig   (sw_trig_w),
      .wd_expire (wd_expire_w),
      .app_mode  (app_mode),
      .in_run    (in_run_w),
      .arm       (arm_w),
      .cause     (cause_w)
   );

   boot_sel_regs #(.ADDR_W(ADDR_W), .WDOG_W(WDOG_W), .DATA_W(DATA_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_addr   (reg_addr),
      .reg_we     (reg_we),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .fetch_ld   (fetch_ld_w),
      .fetch_data (pm_rdata),
      .app_mode   (app_mode),
      .cause      (cause_w),
      .app_addr   (app_addr_w),
      .wd_tmo     (wd_tmo_w),
      .wd_en      (wd_en_w),
      .kick       (kick_w),
      .sw_trig    (sw_trig_w)
   );

   boot_sel_wdog #(.CNT_W(WDOG_W)) u_wdog (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (arm_w | kick_w),
      .load_val (wd_tmo_w),
      .run      (in_run_w & wd_en_w),
      .expire   (wd_expire_w)
   );
endmodule

// File: rtl/boot_image_selector_checker.sv
module boot_image_selector_checker #(
   parameter int ADDR_W = 24
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pm_req,
   input logic              cfg_req,
   input logic              cfg_ack,
   input logic              cfg_err,
   input logic [ADDR_W-1:0] cfg_addr,
   input logic              app_mode,
   input logic [3:0]        cause,
   input logic              wd_expire
);
   a_r1_factory_during_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      pm_req |-> !app_mode);

   a_r2_mode_moves_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_req && cfg_ack) |=> $stable(app_mode));

   a_r8_error_targets_factory: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req && cfg_err && !cfg_ack) |=> (cfg_req && cfg_addr == '0));

   a_r12_cause_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cause));

   a_r12_cause_moves_with_load: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cause) |-> cfg_req);

   a_r5_expire_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wd_expire |=> !wd_expire);

   a_r11_fetch_load_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(pm_req && cfg_req));
endmodule

bind boot_image_selector boot_image_selector_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pm_req    (pm_req),
   .cfg_req   (cfg_req),
   .cfg_ack   (cfg_ack),
   .cfg_err   (cfg_err),
   .cfg_addr  (cfg_addr),
   .app_mode  (app_mode),
   .cause     (cause_w),
   .wd_expire (wd_expire_w)
);

// File: tb/boot_image_selector_test.sv
`timescale 1ns/1ps
module boot_image_selector_test;
   localparam int AW = 24;
   localparam int TW = 29;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pm_req;
   logic [1:0]    pm_addr;
   logic [DW-1:0] pm_rdata = '0;
   logic          pm_ack = 1'b0;
   logic          cfg_req;
   logic [AW-1:0] cfg_addr;
   logic          cfg_ack = 1'b0;
   logic          cfg_err = 1'b0;
   logic          ext_reconfig = 1'b0;
   logic [3:0]    reg_addr = '0;
   logic          reg_we = 1'b0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          app_mode;

   int tests = 0;
   int fails = 0;

   // bench model of the register contents
   logic [DW-1:0] m_tmo, m_en, m_addr, m_mode, m_cause;

   always #2.5 clk = ~clk;

   boot_image_selector #(.ADDR_W(AW), .WDOG_W(TW), .DATA_W(DW)) uut (
      .clk(clk), .rst_n(rst_n), .pm_req(pm_req), .pm_addr(pm_addr),
      .pm_rdata(pm_rdata), .pm_ack(pm_ack), .cfg_req(cfg_req),
      .cfg_addr(cfg_addr), .cfg_ack(cfg_ack), .cfg_err(cfg_err),
      .ext_reconfig(ext_reconfig), .reg_addr(reg_addr), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .app_mode(app_mode)
   );

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] exp_read(input logic [3:0] a);
      case (a)
         4'd0:    return m_mode;
         4'd2:    return m_tmo;
         4'd3:    return m_en;
         4'd4:    return m_addr;
         4'd6:    return m_cause;
         default: return '0;
      endcase
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      pm_ack = 0; cfg_ack = 0; cfg_err = 0; ext_reconfig = 0; reg_we = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      m_tmo = 0; m_en = 0; m_addr = 0; m_mode = 0; m_cause = 0;
      chk("R1 pm_req after reset", DW'(pm_req), 1);
      chk("R1 pm_addr after reset", DW'(pm_addr), 0);
      chk("R1 mode after reset", DW'(app_mode), 0);
   endtask

   task automatic serve_fetch(input logic flag, input logic [DW-1:0] a, input logic [DW-1:0] t);
      for (int i = 0; i < 3; i++) begin
         while (!pm_req) @(negedge clk);
         chk("R1 parameter order", DW'(pm_addr), DW'(i));
         pm_rdata = (i == 0) ? DW'(flag) : (i == 1) ? a : t;
         pm_ack = 1'b1;
         @(negedge clk);
         pm_ack = 1'b0;
      end
      m_en = DW'(flag); m_addr = a & 32'h00FF_FFFF; m_tmo = t & 32'h1FFF_FFFF;
   endtask

   task automatic reg_write(input logic [3:0] a, input logic [DW-1:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
      case (a)
         4'd2: m_tmo  = d & 32'h1FFF_FFFF;
         4'd3: m_en   = d & 32'h1;
         4'd4: m_addr = d & 32'h00FF_FFFF;
         default: ;
      endcase
   endtask

   task automatic reg_read(input logic [3:0] a, output logic [DW-1:0] d);
      reg_addr = a;
      @(negedge clk);
      d = reg_rdata;
   endtask

   task automatic pulse_ack();
      cfg_ack = 1'b1; @(negedge clk); cfg_ack = 1'b0;
   endtask

   // checks cfg_req stays low for t edges, then rises on the next one
   task automatic wdog_window(input string req, input int t);
      int early = 0;
      for (int i = 0; i < t; i++) begin
         @(negedge clk);
         if (cfg_req) early++;
      end
      chk({req, " no early fallback"}, DW'(early), 0);
      @(negedge clk);
      chk({req, " fallback edge"}, DW'(cfg_req), 1);
      chk({req, " fallback address"}, DW'(cfg_addr), 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: bench did not finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [DW-1:0] rd, d;
      logic [3:0] a;
      int idle_req;
      void'($urandom(32'd2024));

      // R1/R2: factory stay when flag clear
      do_reset();
      reg_read(4'd6, rd); chk("R1 cause after reset", rd, 0);
      serve_fetch(1'b0, 32'h0000_1234, 32'd9);
      idle_req = 0;
      repeat (10) begin @(negedge clk); if (cfg_req) idle_req++; end
      chk("R2 no load with flag clear", DW'(idle_req), 0);
      for (int k = 0; k < 9; k++) begin
         reg_read(4'(k), rd); chk("R3 readback after fetch", rd, exp_read(4'(k)));
      end

      // R3/R4: random register traffic in factory mode
      for (int n = 0; n < 60; n++) begin
         a = 4'($urandom_range(0, 15));
         if (a == 4'd7 || a == 4'd8) a = 4'd5;
         if ($urandom_range(0, 1) == 0) begin
            d = $urandom;
            reg_write(a, d);
         end else begin
            reg_read(a, rd); chk("R3 R4 random read", rd, exp_read(a));
         end
      end
      reg_write(4'd0, 32'hFFFF_FFFF);
      reg_write(4'd6, 32'h0000_000F);
      reg_read(4'd0, rd); chk("R4 mode write ignored", rd, 0);
      reg_read(4'd6, rd); chk("R4 cause write ignored", rd, 0);

      // R9: software trigger, R11: external request during load ignored
      reg_write(4'd4, 32'h000A_BCDE);
      reg_write(4'd2, 32'd20);
      reg_write(4'd3, 32'd0);
      reg_write(4'd8, 32'd1);
      chk("R9 trigger raises request", DW'(cfg_req), 1);
      chk("R9 trigger address", DW'(cfg_addr), 32'h000A_BCDE);
      ext_reconfig = 1'b1; @(negedge clk); ext_reconfig = 1'b0;
      chk("R11 target kept during load", DW'(cfg_addr), 32'h000A_BCDE);
      pulse_ack();
      chk("R9 application mode after ack", DW'(app_mode), 1);
      m_mode = 1; m_cause = 32'h4;
      reg_read(4'd6, rd); chk("R9 R11 cause software", rd, 32'h4);
      reg_read(4'd0, rd); chk("R3 mode reads 1", rd, 1);

      // R6: disabled watchdog never fires
      idle_req = 0;
      repeat (60) begin @(negedge clk); if (cfg_req) idle_req++; end
      chk("R6 disabled watchdog silent", DW'(idle_req), 0);

      // R6 resume, then R7 kick restarts count
      reg_write(4'd3, 32'd1);
      repeat (5) @(negedge clk);
      chk("R6 no fallback before kick", DW'(cfg_req), 0);
      reg_write(4'd7, 32'd1);
      wdog_window("R7 R5 kick", 20);
      pulse_ack();
      chk("R5 factory after fallback", DW'(app_mode), 0);
      reg_read(4'd6, rd); chk("R5 cause watchdog", rd, 32'h1);

      // R2/R5: flag set, arm at ack
      do_reset();
      serve_fetch(1'b1, 32'h0004_0000, 32'd12);
      chk("R2 load request", DW'(cfg_req), 1);
      chk("R2 load address", DW'(cfg_addr), 32'h0004_0000);
      pulse_ack();
      chk("R2 application mode", DW'(app_mode), 1);
      wdog_window("R5 arm", 12);
      pulse_ack();
      reg_read(4'd6, rd); chk("R5 cause watchdog", rd, 32'h1);

      // R8: error falls back; R12/R4 cause persists
      do_reset();
      serve_fetch(1'b1, 32'h0000_0123, 32'd50);
      chk("R8 app address first", DW'(cfg_addr), 32'h0000_0123);
      cfg_err = 1'b1; @(negedge clk); cfg_err = 1'b0;
      chk("R8 request held", DW'(cfg_req), 1);
      chk("R8 factory address", DW'(cfg_addr), 0);
      pulse_ack();
      chk("R8 factory mode", DW'(app_mode), 0);
      reg_read(4'd6, rd); chk("R8 cause error", rd, 32'h2);
      reg_write(4'd6, 32'h0000_0008);
      reg_write(4'd0, 32'd1);
      repeat (20) @(negedge clk);
      reg_read(4'd6, rd); chk("R12 R4 cause held", rd, 32'h2);
      reg_read(4'd0, rd); chk("R4 mode held", rd, 0);

      // R10: external beats software trigger in same cycle
      ext_reconfig = 1'b1;
      reg_write(4'd8, 32'd1);
      ext_reconfig = 1'b0;
      chk("R10 ext wins request", DW'(cfg_req), 1);
      chk("R10 ext wins address", DW'(cfg_addr), 0);
      pulse_ack();
      reg_read(4'd6, rd); chk("R10 cause external", rd, 32'h8);

      // R10: external beats watchdog expiry in same cycle
      do_reset();
      serve_fetch(1'b1, 32'h0000_0777, 32'd10);
      pulse_ack();
      idle_req = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (cfg_req) idle_req++;
         if (i == 9) ext_reconfig = 1'b1;
      end
      @(negedge clk);
      ext_reconfig = 1'b0;
      chk("R10 no early request", DW'(idle_req), 0);
      chk("R10 request on collision", DW'(cfg_req), 1);
      pulse_ack();
      reg_read(4'd6, rd); chk("R10 ext over watchdog", rd, 32'h8);

      // R12: only power-on reset clears cause
      do_reset();
      reg_read(4'd6, rd); chk("R12 cleared by reset", rd, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule